// File: doc/BRIEF.md
# Instrument Status Reporting Register Set

This block collects the fault and event sources of a measuring instrument and folds them into a single status byte. It holds two groups of registers. The first group covers six questionable fault conditions that arrive as level inputs. Each condition bit has a rising-edge filter and a falling-edge filter. A filtered edge latches a sticky event bit, and an enable mask selects which event bits feed the summary. The second group covers three standard events. Each one arrives as a one-cycle pulse and latches a sticky bit, and this group has its own enable mask.

A narrow register bus programs and reads the block. Writes take effect at the clock edge. A read returns the data one cycle after the request, on a registered read port. Reading either event register returns its contents and clears it at the same edge. An edge that arrives during that read is kept, not lost. The status byte is also driven continuously on its own output. It combines the two masked summaries with an external output-queue-not-empty flag.

Top module: `instr_status_core`

## Requirements
- R1: Register addresses are: 0 condition (read-only), 1 rising filter, 2 falling filter, 3 questionable event (read-only, clear on read), 4 questionable enable, 5 standard event (read-only, clear on read), 6 standard enable, 7 status byte (read-only). Read data appears on `rd_data` in the cycle after `rd_en`. Questionable fields use bits 5:0, and bits 7:6 read as zero.
- R2: Reading address 0 returns the live fault inputs: bit 0 over-voltage range, 1 over-current range, 2 over-current, 3 integration range change, 4 inrush range change, 5 energy range change.
- R3: A 0-to-1 change of a fault input, against its value one clock earlier, sets the matching questionable event bit when the rising filter bit is 1.
- R4: A 1-to-0 change of a fault input sets the matching event bit when the falling filter bit is 1. An edge whose filter bit is 0 leaves the event bit unchanged.
- R5: Event bits stay set until a read of their register. That read returns the current value and leaves the register zero.
- R6: If a qualifying edge or pulse arrives in the same cycle as the clearing read, its bit is set after the read.
- R7: Status byte bit 3 is 1 exactly when any questionable event bit and its enable bit are both 1.
- R8: Status byte bit 4 follows the `oq_avail` input.
- R9: Pulses on `opc_pulse`, `qye_pulse` and `dde_pulse` set standard event bits 0, 2 and 3. Status byte bit 5 is the OR of the standard event bits ANDed with the standard enable.
- R10: After reset the rising filter reads 0x3F. The falling filter, both enables and both event registers read zero.
- R11: Status byte bits 7:6 and 2:0 are always zero. Writes to the read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| fault_lvl | input | 6 | Questionable fault levels |
| oq_avail | input | 1 | Output queue holds data |
| opc_pulse | input | 1 | Operation-complete pulse |
| qye_pulse | input | 1 | Query-error pulse |
| dde_pulse | input | 1 | Device-dependent-error pulse |
| status_byte | output | 8 | Combined status summary |

## Verification
A bad previous-value register or a wrong filter term shows up one edge after the stimulus. The event readback then shows a missing or spurious bit, and status byte bit 3 moves or fails to move when the enable is set. A clear that drops a colliding edge is caught by a second read one access later, which must still show the bit. Mask or summary wiring errors reach the status byte immediately. The bench reads the byte both on its own port and through address 7.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW = 8;
  localparam int QW = 6;
  localparam int AW = 3;

  localparam int QSUM_BIT = 3;
  localparam int MAV_BIT  = 4;
  localparam int ESB_BIT  = 5;

  localparam int OPC_BIT = 0;
  localparam int QYE_BIT = 2;
  localparam int DDE_BIT = 3;

  typedef enum logic [AW-1:0] {
    A_COND  = 3'd0,
    A_PFILT = 3'd1,
    A_NFILT = 3'd2,
    A_QEVT  = 3'd3,
    A_QMASK = 3'd4,
    A_SEVT  = 3'd5,
    A_SMASK = 3'd6,
    A_SBYTE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/stat_edge_filter.sv
module stat_edge_filter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      hit_o[i] = (rise_en_i[i] &  lvl_i[i] & ~prev_q[i]) |
                 (fall_en_i[i] & ~lvl_i[i] &  prev_q[i]);
    end
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/stat_sticky.sv
module stat_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr_i ? '0 : q) | set_i;
  end

  assign q_o = q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (set_i == '0)) |=> (q_o == '0));

  assert_keep_new_R6: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/stat_summary.sv
module stat_summary
  import stat_pkg::*;
(
  input  logic [QW-1:0] qev_i,
  input  logic [QW-1:0] qmask_i,
  input  logic [DW-1:0] sev_i,
  input  logic [DW-1:0] smask_i,
  input  logic          oq_i,
  output logic [DW-1:0] sb_o
);
  always_comb begin
    sb_o           = '0;
    sb_o[QSUM_BIT] = |(qev_i & qmask_i);
    sb_o[MAV_BIT]  = oq_i;
    sb_o[ESB_BIT]  = |(sev_i & smask_i);
  end
endmodule

// File: rtl/instr_status_core.sv
module instr_status_core
  import stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [QW-1:0] fault_lvl,
  input  logic          oq_avail,
  input  logic          opc_pulse,
  input  logic          qye_pulse,
  input  logic          dde_pulse,
  output logic [DW-1:0] status_byte
);
  localparam logic [DW-1:0] QPAD = '0;

  reg_addr_e     a;
  logic [QW-1:0] pfilt, nfilt, qmask;
  logic [DW-1:0] smask;
  logic [QW-1:0] qhit, prev, qev;
  logic [DW-1:0] sset, sev;
  logic          qclr, sclr;
  logic [DW-1:0] rd_mux;

  assign a    = reg_addr_e'(addr);
  assign qclr = rd_en && (a == A_QEVT);
  assign sclr = rd_en && (a == A_SEVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pfilt <= '1;
      nfilt <= '0;
      qmask <= '0;
      smask <= '0;
    end else if (wr_en) begin
      case (a)
        A_PFILT: pfilt <= wr_data[QW-1:0];
        A_NFILT: nfilt <= wr_data[QW-1:0];
        A_QMASK: qmask <= wr_data[QW-1:0];
        A_SMASK: smask <= wr_data;
        default: ;
      endcase
    end
  end

  stat_edge_filter #(.W(QW)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(fault_lvl),
    .rise_en_i(pfilt), .fall_en_i(nfilt),
    .prev_o(prev), .hit_o(qhit)
  );

  stat_sticky #(.W(QW)) u_qev (
    .clk(clk), .rst(rst), .set_i(qhit), .clr_i(qclr), .q_o(qev)
  );

  always_comb begin
    sset          = '0;
    sset[OPC_BIT] = opc_pulse;
    sset[QYE_BIT] = qye_pulse;
    sset[DDE_BIT] = dde_pulse;
  end

  stat_sticky #(.W(DW)) u_sev (
    .clk(clk), .rst(rst), .set_i(sset), .clr_i(sclr), .q_o(sev)
  );

  stat_summary u_sum (
    .qev_i(qev), .qmask_i(qmask), .sev_i(sev), .smask_i(smask),
    .oq_i(oq_avail), .sb_o(status_byte)
  );

  always_comb begin
    rd_mux = QPAD;
    case (a)
      A_COND:  rd_mux[QW-1:0] = fault_lvl;
      A_PFILT: rd_mux[QW-1:0] = pfilt;
      A_NFILT: rd_mux[QW-1:0] = nfilt;
      A_QEVT:  rd_mux[QW-1:0] = qev;
      A_QMASK: rd_mux[QW-1:0] = qmask;
      A_SEVT:  rd_mux         = sev;
      A_SMASK: rd_mux         = smask;
      A_SBYTE: rd_mux         = status_byte;
      default: rd_mux         = QPAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  for (genvar i = 0; i < QW; i++) begin : g_chk
    assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
      (fault_lvl[i] && !prev[i] && pfilt[i]) |=> qev[i]);
    assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
      (!fault_lvl[i] && prev[i] && nfilt[i]) |=> qev[i]);
  end

  assert_qsum_R7: assert property (@(posedge clk) disable iff (rst)
    status_byte[QSUM_BIT] == |(qev & qmask));

  assert_opc_R9: assert property (@(posedge clk) disable iff (rst)
    opc_pulse |=> sev[OPC_BIT]);

  assert_pad_R11: assert property (@(posedge clk) disable iff (rst)
    (status_byte[7:6] == 2'b00) && (status_byte[2:0] == 3'b000));
endmodule

// File: tb/sim_instr_status_core.sv
module sim_instr_status_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [5:0] fault_lvl = '0;
  logic       oq_avail = 1'b0;
  logic       opc_pulse = 1'b0, qye_pulse = 1'b0, dde_pulse = 1'b0;
  logic [7:0] status_byte;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  instr_status_core u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .fault_lvl(fault_lvl),
    .oq_avail(oq_avail), .opc_pulse(opc_pulse), .qye_pulse(qye_pulse),
    .dde_pulse(dde_pulse), .status_byte(status_byte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd1, d); chk("R10 pfilt", d, 8'h3F);
    rd(3'd2, d); chk("R10 nfilt", d, 8'h00);
    rd(3'd4, d); chk("R10 qmask", d, 8'h00);
    rd(3'd6, d); chk("R10 smask", d, 8'h00);
    rd(3'd3, d); chk("R10 qevt", d, 8'h00);
    rd(3'd5, d); chk("R10 sevt", d, 8'h00);
    chk("R10 sbyte", status_byte, 8'h00);
  endtask

  task automatic t_cond();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    fault_lvl = 6'b101001;
    rd(3'd0, d); chk("R2 cond", d, 8'h29);
    fault_lvl = 6'b000000;
    rd(3'd0, d); chk("R2 cond clear", d, 8'h00);
    rd(3'd3, d); chk("R4 no filter", d, 8'h00);
    wr(3'd1, 8'h3F);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    fault_lvl = 6'b000100;
    tick();
    fault_lvl = 6'b000000;
    tick(); tick();
    rd(3'd3, d); chk("R3 rise sticky", d, 8'h04);
    rd(3'd3, d); chk("R5 cleared", d, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h20);
    fault_lvl = 6'b100010;
    tick();
    rd(3'd3, d); chk("R4 rise masked", d, 8'h00);
    fault_lvl = 6'b000000;
    tick();
    rd(3'd3, d); chk("R4 fall", d, 8'h20);
    wr(3'd1, 8'h3F);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    fault_lvl = 6'b000001;
    tick();
    rd_en = 1'b1; addr = 3'd3; fault_lvl = 6'b000011;
    tick();
    rd_en = 1'b0;
    chk("R6 read old", rd_data, 8'h01);
    rd(3'd3, d); chk("R6 kept", d, 8'h02);
    fault_lvl = 6'b000000;
    tick();
  endtask

  task automatic t_qsum();
    logic [7:0] d;
    fault_lvl = 6'b010000;
    tick();
    chk("R7 masked off", status_byte, 8'h00);
    wr(3'd4, 8'h08);
    chk("R7 other mask", status_byte, 8'h00);
    wr(3'd4, 8'h10);
    chk("R7 sum", status_byte, 8'h08);
    rd(3'd3, d);
    chk("R7 after clear", status_byte, 8'h00);
    fault_lvl = 6'b000000;
    tick();
    wr(3'd4, 8'h00);
  endtask

  task automatic t_mav();
    oq_avail = 1'b1;
    #1 chk("R8 mav on", status_byte, 8'h10);
    oq_avail = 1'b0;
    #1 chk("R8 mav off", status_byte, 8'h00);
  endtask

  task automatic t_std();
    logic [7:0] d;
    qye_pulse = 1'b1;
    tick();
    qye_pulse = 1'b0;
    chk("R9 no enable", status_byte, 8'h00);
    wr(3'd6, 8'h04);
    chk("R9 esb", status_byte, 8'h20);
    opc_pulse = 1'b1; dde_pulse = 1'b1;
    tick();
    opc_pulse = 1'b0; dde_pulse = 1'b0;
    rd_en = 1'b1; addr = 3'd5; opc_pulse = 1'b1;
    tick();
    rd_en = 1'b0; opc_pulse = 1'b0;
    chk("R9 sevt", rd_data, 8'h0D);
    rd(3'd5, d); chk("R6 std kept", d, 8'h01);
    chk("R9 esb cleared", status_byte, 8'h00);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    wr(3'd7, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd5, 8'hFF);
    chk("R11 sbyte", status_byte, 8'h00);
    rd(3'd3, d); chk("R11 qevt ro", d, 8'h00);
    rd(3'd5, d); chk("R11 sevt ro", d, 8'h00);
    oq_avail = 1'b1;
    rd(3'd7, d); chk("R1 sbyte addr", d, 8'h10);
    oq_avail = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_cond();
    t_rise();
    t_fall();
    t_collide();
    t_qsum();
    t_mav();
    t_std();
    t_ro();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule